// File: doc/BRIEF.md
# Suspendable Block Erase Sequencer

This block is the internal engine that erases one block of a byte-wide behavioral flash array after a command decoder hands it a start strobe and a block number. With no further host involvement it first programs every byte of the block to 00h (preconditioning). It then applies erase pulses and verifies that every byte reads FFh. A byte that is not FFh triggers another pulse, up to a fixed pulse limit. The phases are modelled as cycle counts. The array has a per-operation "cell hardness" input that sets how many pulses the block needs before it reads erased.

While it runs, the ready/busy output is low and host reads return the status word. A suspend request is held until the next safe point, which is the end of an erase pulse or the end of a phase. At that point the sequencer parks, releases ready/busy and lets the host read blocks other than the one being erased. A resume continues with the phase that would have come next. If the programming voltage is lost during an erase or a suspension, the operation is abandoned and the voltage and erase error flags are raised.

Top module: `blkerase_seq`

## Requirements
- R1: After a start strobe with voltage good, ready goes low on the next cycle. With B bytes per block, P cycles per pulse and effective hardness h' = max(h,1) no larger than the pulse limit M, the erase stays busy for exactly 2B + h'P + (h'-1) cycles. It then leaves every byte of that block at FFh and leaves the other blocks untouched.
- R2: While the sequencer is running (not suspended), ready is 0 and the host read port returns the status word. The status word has bit 7 = sequencer ready, bit 6 = erase suspended, bit 5 = erase error and bit 3 = voltage error; every other bit is 0.
- R3: A suspend request is honoured only at the end of the preconditioning phase, at the end of an erase pulse, or after a failed verify. A request made during a pulse takes effect when that pulse ends.
- R4: While suspended, status bits 7 and 6 are both 1 and ready is 1, so the status word is C0h.
- R5: A resume while suspended clears status bits 7 and 6 and drives ready low on the next cycle. The erase continues where it stopped, so the busy time before and after the suspension adds up to the R1 total.
- R6: If the verify still finds a byte other than FFh after M pulses, the erase ends and status bit 5 is set. For h' > M the erase is busy for B + MP + M cycles, and the block is left at 00h.
- R7: While suspended, host reads of any other block return the array contents, and reads of the suspended block return the status word.
- R8: If the voltage-good input drops while the sequencer is running or suspended, it returns to ready on the next cycle with status bits 3 and 5 set (status A8h).
- R9: A start while the voltage is low starts no erase and sets bits 3 and 5. A start while bit 3 is already set is ignored.
- R10: The clear input resets status bits 5 and 3. Otherwise those bits stay set.
- R11: A resume when not suspended and a suspend while idle have no effect. A later erase runs with the R1 busy time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears status and array to 00h |
| start_i | input | 1 | One-cycle erase start strobe |
| blk_i | input | BLK_W | Block number to erase, sampled with start_i |
| suspend_i | input | 1 | Suspend request strobe |
| resume_i | input | 1 | Resume strobe |
| clr_i | input | 1 | Clear status error bits |
| vpp_ok_i | input | 1 | Programming voltage is high |
| hard_i | input | HARD_W | Pulses the addressed block needs before it reads erased |
| rd_addr_i | input | ADDR_W | Host read address {block, offset} |
| rd_data_o | output | 8 | Host read data: array byte or status word |
| status_o | output | 8 | Status word |
| ready_o | output | 1 | Ready/busy: 1 = ready or suspended |

## Verification
A wrong internal state shows up at the ports as a busy time that differs from the closed-form cycle count, because every phase adds a fixed number of cycles. The error shows as soon as ready returns high. A suspension taken at the wrong point shows as a busy count before ready rises that is not a phase or pulse boundary, or as a before-plus-after total that differs from the uninterrupted run. Wrong array contents or a wrong read mux show within one cycle on rd_data_o, when the bench compares each byte with FFh, 00h or the status word.

// File: rtl/bes_pkg.sv
package bes_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PRE   = 3'd1,
    S_PULSE = 3'd2,
    S_VER   = 3'd3,
    S_SUSP  = 3'd4
  } bes_state_e;

  // status word layout: 7 ready, 6 suspended, 5 erase error, 3 voltage error
  function automatic logic [7:0] stat_word(input logic rdy, input logic sus,
                                           input logic eer, input logic verr);
    return {rdy, sus, eer, 1'b0, verr, 3'b000};
  endfunction

  // true when the pulse just finished brings the block to its erased level
  function automatic logic pulse_erases(input int pulses_before, input int hardness);
    return (pulses_before + 1) >= hardness;
  endfunction
endpackage

// File: rtl/bes_fsm.sv
module bes_fsm
  import bes_pkg::*;
#(
  parameter int NUM_BLK    = 4,
  parameter int BLK_BYTES  = 16,
  parameter int PULSE_CYC  = 8,
  parameter int MAX_PULSES = 3,
  localparam int BLK_W = $clog2(NUM_BLK),
  localparam int OFF_W = $clog2(BLK_BYTES),
  localparam int CNT_W = $clog2(BLK_BYTES > PULSE_CYC ? BLK_BYTES : PULSE_CYC) + 1,
  localparam int PC_W  = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  input  logic             clr_i,
  input  logic             vpp_ok_i,
  input  logic [7:0]       ver_byte_i,
  output bes_state_e       st_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [OFF_W-1:0] off_o,
  output logic             pre_we_o,
  output logic             pulse_done_o,
  output logic [PC_W-1:0]  pulses_o,
  output logic             phase_end_o,
  output logic             run_o,
  output logic             eer_o,
  output logic             verr_o
);
  bes_state_e       st_q, resume_st_q, nx;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  pulses_q;
  logic [BLK_W-1:0] blk_q;
  logic             sp_pend_q, eer_q, verr_q;
  logic             phase_end, fin, fail;

  assign run_o = (st_q == S_PRE) || (st_q == S_PULSE) || (st_q == S_VER);

  // next-phase decode; phase_end marks the safe suspend points
  always_comb begin
    phase_end = 1'b0;
    fin       = 1'b0;
    fail      = 1'b0;
    nx        = S_IDLE;
    case (st_q)
      S_PRE: if (cnt_q == CNT_W'(BLK_BYTES - 1)) begin
        phase_end = 1'b1;
        nx        = S_PULSE;
      end
      S_PULSE: if (cnt_q == CNT_W'(PULSE_CYC - 1)) begin
        phase_end = 1'b1;
        nx        = S_VER;
      end
      S_VER: begin
        if (ver_byte_i != 8'hFF) begin
          if (pulses_q == PC_W'(MAX_PULSES)) fail = 1'b1;
          else begin
            phase_end = 1'b1;
            nx        = S_PULSE;
          end
        end else if (cnt_q == CNT_W'(BLK_BYTES - 1)) begin
          fin = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      resume_st_q <= S_IDLE;
      cnt_q       <= '0;
      pulses_q    <= '0;
      blk_q       <= '0;
      sp_pend_q   <= 1'b0;
      eer_q       <= 1'b0;
      verr_q      <= 1'b0;
    end else begin
      if (clr_i) begin
        eer_q  <= 1'b0;
        verr_q <= 1'b0;
      end
      if (suspend_i && run_o) sp_pend_q <= 1'b1;
      if (st_q == S_IDLE) begin
        if (start_i) begin
          if (!vpp_ok_i) begin
            verr_q <= 1'b1;
            eer_q  <= 1'b1;
          end else if (!verr_q) begin
            blk_q    <= blk_i;
            cnt_q    <= '0;
            pulses_q <= '0;
            st_q     <= S_PRE;
          end
        end
      end else if (!vpp_ok_i) begin
        st_q      <= S_IDLE;
        verr_q    <= 1'b1;
        eer_q     <= 1'b1;
        sp_pend_q <= 1'b0;
      end else if (st_q == S_SUSP) begin
        if (resume_i) st_q <= resume_st_q;
      end else if (fin || fail) begin
        st_q      <= S_IDLE;
        sp_pend_q <= 1'b0;
        if (fail) eer_q <= 1'b1;
      end else if (phase_end) begin
        cnt_q <= '0;
        if (st_q == S_PULSE) pulses_q <= pulses_q + 1'b1;
        if (sp_pend_q || suspend_i) begin
          st_q        <= S_SUSP;
          resume_st_q <= nx;
          sp_pend_q   <= 1'b0;
        end else begin
          st_q <= nx;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign st_o         = st_q;
  assign blk_o        = blk_q;
  assign off_o        = cnt_q[OFF_W-1:0];
  assign pre_we_o     = (st_q == S_PRE);
  assign pulse_done_o = (st_q == S_PULSE) && phase_end;
  assign pulses_o     = pulses_q;
  assign phase_end_o  = phase_end;
  assign eer_o        = eer_q;
  assign verr_o       = verr_q;
endmodule

// File: rtl/bes_array.sv
module bes_array
  import bes_pkg::*;
#(
  parameter int NUM_BLK    = 4,
  parameter int BLK_BYTES  = 16,
  parameter int MAX_PULSES = 3,
  parameter int HARD_W     = 3,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int ADDR_W = BLK_W + OFF_W,
  localparam int PC_W   = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              pre_we_i,
  input  logic              pulse_done_i,
  input  logic [PC_W-1:0]   pulses_i,
  input  logic [HARD_W-1:0] hard_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_byte_o,
  output logic [7:0]        ver_byte_o
);
  localparam int DEPTH = NUM_BLK * BLK_BYTES;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (pre_we_i) begin
      mem_q[{blk_i, off_i}] <= 8'h00;
    end else if (pulse_done_i && pulse_erases(int'(pulses_i), int'(hard_i))) begin
      for (int i = 0; i < BLK_BYTES; i++) mem_q[{blk_i, OFF_W'(i)}] <= 8'hFF;
    end
  end

  assign rd_byte_o  = mem_q[rd_addr_i];
  assign ver_byte_o = mem_q[{blk_i, off_i}];
endmodule

// File: rtl/blkerase_seq.sv
module blkerase_seq
  import bes_pkg::*;
#(
  parameter int NUM_BLK    = 4,
  parameter int BLK_BYTES  = 16,
  parameter int PULSE_CYC  = 8,
  parameter int MAX_PULSES = 3,
  parameter int HARD_W     = 3,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int ADDR_W = BLK_W + OFF_W,
  localparam int PC_W   = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              clr_i,
  input  logic              vpp_ok_i,
  input  logic [HARD_W-1:0] hard_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        status_o,
  output logic              ready_o
);
  bes_state_e       st_w;
  logic [BLK_W-1:0] blk_w;
  logic [OFF_W-1:0] off_w;
  logic [PC_W-1:0]  pulses_w;
  logic [7:0]       ver_byte_w, arr_byte_w;
  logic             pre_we_w, pulse_done_w, phase_end_w, run_w, eer_w, verr_w;
  logic             susp_w, hide_w;

  bes_fsm #(
    .NUM_BLK(NUM_BLK), .BLK_BYTES(BLK_BYTES),
    .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_i(blk_i),
    .suspend_i(suspend_i), .resume_i(resume_i), .clr_i(clr_i),
    .vpp_ok_i(vpp_ok_i), .ver_byte_i(ver_byte_w), .st_o(st_w),
    .blk_o(blk_w), .off_o(off_w), .pre_we_o(pre_we_w),
    .pulse_done_o(pulse_done_w), .pulses_o(pulses_w),
    .phase_end_o(phase_end_w), .run_o(run_w), .eer_o(eer_w), .verr_o(verr_w)
  );

  bes_array #(
    .NUM_BLK(NUM_BLK), .BLK_BYTES(BLK_BYTES),
    .MAX_PULSES(MAX_PULSES), .HARD_W(HARD_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .blk_i(blk_w), .off_i(off_w),
    .pre_we_i(pre_we_w), .pulse_done_i(pulse_done_w), .pulses_i(pulses_w),
    .hard_i(hard_i), .rd_addr_i(rd_addr_i), .rd_byte_o(arr_byte_w),
    .ver_byte_o(ver_byte_w)
  );

  assign susp_w   = (st_w == S_SUSP);
  assign ready_o  = !run_w;
  assign status_o = stat_word(!run_w, susp_w, eer_w, verr_w);
  // the block under erase is never visible while the operation is open
  assign hide_w    = run_w || (susp_w && (rd_addr_i[ADDR_W-1:OFF_W] == blk_w));
  assign rd_data_o = hide_w ? status_o : arr_byte_w;
endmodule

// File: rtl/bes_chk.sv
module bes_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       resume_i,
  input logic       clr_i,
  input logic       vpp_ok_i,
  input logic       ready_o,
  input logic [7:0] status_o,
  input logic [7:0] rd_data_o,
  input logic       phase_end_w,
  input logic       run_w
);
  assert_susp_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] |-> (status_o[7] && ready_o));

  assert_susp_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[6]) |-> $past(phase_end_w));

  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] && resume_i && vpp_ok_i) |=> (!status_o[6] && !status_o[7] && !ready_o));

  assert_busy_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (rd_data_o == status_o));

  assert_vpp_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_w || status_o[6]) && !vpp_ok_i) |=>
      (ready_o && status_o[3] && status_o[5] && !status_o[6]));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] && !clr_i) |=> status_o[5]);
endmodule

bind blkerase_seq bes_chk u_chk (
  .clk(clk), .rst_n(rst_n), .resume_i(resume_i), .clr_i(clr_i),
  .vpp_ok_i(vpp_ok_i), .ready_o(ready_o), .status_o(status_o),
  .rd_data_o(rd_data_o), .phase_end_w(phase_end_w), .run_w(run_w)
);

// File: tb/blkerase_seq_tb.sv
`timescale 1ns/1ps
module blkerase_seq_tb;
  localparam int B = 16, P = 8, M = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start_i = 0, suspend_i = 0, resume_i = 0, clr_i = 0, vpp_ok_i = 1;
  logic [1:0] blk_i = 0;
  logic [2:0] hard_i = 0;
  logic [5:0] rd_addr_i = 0;
  logic [7:0] rd_data_o, status_o;
  logic       ready_o;
  int n_chk = 0, n_fail = 0;
  int busy;

  always #2.5 clk = ~clk;

  blkerase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_i(blk_i),
    .suspend_i(suspend_i), .resume_i(resume_i), .clr_i(clr_i),
    .vpp_ok_i(vpp_ok_i), .hard_i(hard_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .status_o(status_o), .ready_o(ready_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_busy(input int h);
    int hh = (h < 1) ? 1 : h;
    if (hh > M) return B + M * P + M;
    return 2 * B + hh * P + (hh - 1);
  endfunction

  task automatic strobe_start(input int b, input int h);
    blk_i = 2'(b); hard_i = 3'(h); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  // counts busy cycles; raises suspend once when the count reaches sus_at
  task automatic count_busy(input int sus_at, output int n, output int bad_rd);
    n = 0; bad_rd = 0;
    while (!ready_o && n < 5000) begin
      n++;
      if (rd_data_o !== status_o) bad_rd++;
      suspend_i = (n == sus_at);
      @(negedge clk);
    end
    suspend_i = 0;
  endtask

  task automatic blk_all(input int b, input logic [7:0] v, input string tag);
    int bad = 0;
    for (int i = 0; i < B; i++) begin
      rd_addr_i = 6'(b * B + i); #0.1;
      if (rd_data_o !== v) bad++;
    end
    chk(tag, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad, n2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset status", status_o, 8'h80);
    chk("R2 reset ready", ready_o, 1);
    rd_addr_i = 6'd5; #0.1;
    chk("R1 reset array", rd_data_o, 8'h00);

    // R1/R6 sweep of hardness 0..7 over the blocks
    for (int h = 0; h < 8; h++) begin
      clr_i = 1; @(negedge clk); clr_i = 0;
      strobe_start(h % 4, h);
      count_busy(-1, busy, bad);
      chk($sformatf("R1 R6 busy h=%0d", h), busy, exp_busy(h));
      chk($sformatf("R2 busy reads h=%0d", h), bad, 0);
      chk($sformatf("R6 status h=%0d", h), status_o, (h > M) ? 8'hA0 : 8'h80);
      blk_all(h % 4, (h > M) ? 8'h00 : 8'hFF, $sformatf("R1 R6 contents h=%0d", h));
      if (h == 0) blk_all(1, 8'h00, "R1 neighbour untouched");
    end
    clr_i = 1; @(negedge clk); clr_i = 0;

    // R11: stray resume/suspend while idle
    resume_i = 1; suspend_i = 1; @(negedge clk); resume_i = 0; suspend_i = 0;
    chk("R11 idle status", status_o, 8'h80);
    strobe_start(1, 1);
    count_busy(-1, busy, bad);
    chk("R11 busy after stray strobes", busy, exp_busy(1));

    // R3/R4/R5/R7: suspend during preconditioning of block 2
    strobe_start(2, 2);
    count_busy(3, busy, bad);
    chk("R3 suspend at phase end", busy, B);
    repeat (10) @(negedge clk);
    chk("R4 suspended status", status_o, 8'hC0);
    chk("R4 ready while suspended", ready_o, 1);
    rd_addr_i = 6'(1 * B + 3); #0.1;
    chk("R7 other block readable", rd_data_o, 8'hFF);
    rd_addr_i = 6'(2 * B + 3); #0.1;
    chk("R7 suspended block hidden", rd_data_o, 8'hC0);
    resume_i = 1; @(negedge clk); resume_i = 0;
    chk("R5 status after resume", status_o, 8'h00);
    count_busy(-1, n2, bad);
    chk("R5 remaining busy", busy + 1 + n2, exp_busy(2) + 1);
    blk_all(2, 8'hFF, "R5 erase completed");

    // R3: suspend during a pulse waits for its end
    strobe_start(3, 1);
    count_busy(B + 2, busy, bad);
    chk("R3 suspend at pulse end", busy, B + P);
    chk("R4 status at pulse suspend", status_o, 8'hC0);
    resume_i = 1; @(negedge clk); resume_i = 0;
    count_busy(-1, n2, bad);
    chk("R5 remaining after pulse suspend", busy + 1 + n2, exp_busy(1) + 1);

    // R8: voltage loss while running
    strobe_start(0, 1);
    repeat (4) @(negedge clk);
    vpp_ok_i = 0; @(negedge clk);
    chk("R8 abort running", status_o, 8'hA8);
    chk("R8 ready after abort", ready_o, 1);
    vpp_ok_i = 1;
    // R9: start ignored while voltage error is set
    strobe_start(0, 1);
    chk("R9 start blocked by vpp error", ready_o, 1);
    // R10 clear
    clr_i = 1; @(negedge clk); clr_i = 0;
    chk("R10 clear status", status_o, 8'h80);

    // R8: voltage loss while suspended
    strobe_start(0, 1);
    count_busy(2, busy, bad);
    chk("R4 suspended again", status_o, 8'hC0);
    vpp_ok_i = 0; @(negedge clk);
    chk("R8 abort suspended", status_o, 8'hA8);
    // R9: start with voltage low
    clr_i = 1; @(negedge clk); clr_i = 0;
    strobe_start(1, 1);
    chk("R9 start low voltage", status_o, 8'hA8);
    rd_addr_i = 6'(1 * B); #0.1;
    chk("R9 nothing erased", rd_data_o, 8'hFF);
    vpp_ok_i = 1;
    repeat (3) @(negedge clk);
    chk("R10 error sticky", status_o, 8'hA8);
    clr_i = 1; @(negedge clk); clr_i = 0;
    chk("R10 cleared again", status_o, 8'h80);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule